// File: doc/BRIEF.md
# Disk Controller Operating Mode Sequencer

This block decides which of three host-interface personalities a floppy-disk controller presents: Base, Special or PC AT. It sits next to the register decoder. It watches one-cycle host access strobes, each tagged as a read or write to the status, operations or control register, and keeps the six operations-register bits it needs. From its mode it drives the device soft reset, the output enables of the interrupt and DMA request pins, the DMA request qualifier, the four drive-select pins and the dual-purpose write-current/spindle-speed pin.

After a hardware reset the controller waits in a reset-hold state with both request pins tristated. The first host access picks the personality. A write to the operations register selects PC AT; any other access selects Base. Moving between Special and PC AT takes two steps: software writes a specific operations-register pattern, which arms the move, and then reads the control register, which completes it.

Top module: `fdc_mode_seq`

## Requirements
- R1: While `rst_hw` is high, and until the first host access after it, `mode` is 0 (reset-hold), `soft_rst` is 1, `irq_oe`, `dma_oe` and `dma_req_q` are 0, `ds_n` is 4'b1111 and `rwc_n` is 1.
- R2: In reset-hold, an access strobe (`acc_stb`=1) that is not an operations write moves the block to Base (`mode`=1) on that clock edge. From then on `soft_rst` is 0, and `irq_oe` and `dma_oe` are 1 until the next hardware reset.
- R3: In Base the stored operations bits have no effect: `soft_rst` stays 0 and `dma_req_q` equals `dma_req_in`.
- R4: An operations write (`acc_wr`=1, `acc_reg`=2'b01) in reset-hold or Base moves the block to PC AT (`mode`=3) on that edge and stores the written byte.
- R5: In PC AT, an operations write whose value has bit 7 = 1, bits 5:4 = 00 and bit 2 = 0 arms Special entry. A following control read (`acc_wr`=0, `acc_reg`=2'b10) moves the block to Special (`mode`=2).
- R6: In Special, an operations write whose value has bit 7 = 0, bits 5:4 = 00 and bit 2 = 0 arms PC AT entry. A following control read moves the block to PC AT.
- R7: Any operations write whose value does not match a pattern clears that pattern's arm. Every control read clears both arms. A control read with no matching arm leaves `mode` unchanged.
- R8: In Base and Special, `ds_n` is an active-low one-of-four decode of `unit_sel`: `ds_n[k]` is 0 exactly when `unit_sel` = k.
- R9: In PC AT, `ds_n` = {~ops[5], ~ops[4], ~ops[1], ~ops[0]}, where ops is the last byte written to the operations register. Bits 5:4 are the motor enables and bits 1:0 are the drive selects.
- R10: In Special and PC AT, `dma_req_q` = `dma_req_in` AND ops[3] (DMA enable), and `soft_rst` = NOT ops[2] (bit 2 is an active-low soft reset).
- R11: `rwc_n` is the active-low spindle-speed select ~`slow_rate` in PC AT. It is the active-low reduce-write-current ~`wcur_req` in Base and Special.
- R12: `mode` encoding: 0 reset-hold, 1 Base, 2 Special, 3 PC AT. `acc_reg` encoding: 00 status, 01 operations, 10 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hw | input | 1 | Hardware reset, active high, asynchronous |
| acc_stb | input | 1 | One-cycle host register access strobe |
| acc_wr | input | 1 | Access is a write (1) or a read (0) |
| acc_reg | input | 2 | Register accessed: 00 status, 01 operations, 10 control |
| ops_wdata | input | 8 | Byte written on an operations write |
| unit_sel | input | 2 | Unit-select field of the current command |
| dma_req_in | input | 1 | Raw DMA request from the data path |
| wcur_req | input | 1 | Reduce-write-current request from precompensation logic |
| slow_rate | input | 1 | Slower data rate selected for the current drive |
| mode | output | 2 | Current mode (see R12) |
| soft_rst | output | 1 | Internal device reset, active high |
| irq_oe | output | 1 | Output enable of the interrupt request pin |
| dma_oe | output | 1 | Output enable of the DMA request pin |
| dma_req_q | output | 1 | Qualified DMA request |
| ds_n | output | 4 | Drive-select pins, active low |
| rwc_n | output | 1 | Write-current / spindle-speed pin, active low |

## Verification
On every cycle the assertions check the following. Reset-hold keeps soft reset on and both request pins disabled. Base never shows a soft reset and passes the DMA request through unqualified. Base and Special show exactly one active drive select, the one `unit_sel` names. Hold can only be left by an access, and it is never re-entered without a hardware reset. Only the scenarios can show that the two-step pattern-then-control-read sequence arms, clears and consumes correctly, that the PC AT pins mirror the stored byte bit for bit, and that the write-current/speed pin changes its source with the mode.

// File: rtl/fdc_mode_seq.sv
module fdc_mode_seq (
  input  logic       clk,
  input  logic       rst_hw,
  input  logic       acc_stb,
  input  logic       acc_wr,
  input  logic [1:0] acc_reg,
  input  logic [7:0] ops_wdata,
  input  logic [1:0] unit_sel,
  input  logic       dma_req_in,
  input  logic       wcur_req,
  input  logic       slow_rate,
  output logic [1:0] mode,
  output logic       soft_rst,
  output logic       irq_oe,
  output logic       dma_oe,
  output logic       dma_req_q,
  output logic [3:0] ds_n,
  output logic       rwc_n
);
  localparam logic [1:0] M_HOLD = 2'd0;
  localparam logic [1:0] M_BASE = 2'd1;
  localparam logic [1:0] M_SPEC = 2'd2;
  localparam logic [1:0] M_AT   = 2'd3;
  localparam logic [1:0] REG_OPS = 2'b01;
  localparam logic [1:0] REG_CTL = 2'b10;
  localparam logic [7:0] PAT_MASK = 8'hB4;
  localparam logic [7:0] PAT_SPEC = 8'h80;
  localparam logic [7:0] PAT_AT   = 8'h00;

  logic [5:0] ops_q;
  logic       arm_spec, arm_at;
  logic       ops_wr, ctl_rd, hit_spec, hit_at;

  assign ops_wr   = acc_stb &  acc_wr & (acc_reg == REG_OPS);
  assign ctl_rd   = acc_stb & ~acc_wr & (acc_reg == REG_CTL);
  assign hit_spec = (ops_wdata & PAT_MASK) == PAT_SPEC;
  assign hit_at   = (ops_wdata & PAT_MASK) == PAT_AT;

  always_ff @(posedge clk or posedge rst_hw) begin
    if (rst_hw) begin
      mode     <= M_HOLD;
      ops_q    <= '0;
      arm_spec <= 1'b0;
      arm_at   <= 1'b0;
    end else begin
      if (ops_wr) begin
        ops_q    <= ops_wdata[5:0];
        arm_spec <= hit_spec;
        arm_at   <= hit_at;
      end else if (ctl_rd) begin
        arm_spec <= 1'b0;
        arm_at   <= 1'b0;
      end
      case (mode)
        M_HOLD:  if (acc_stb) mode <= ops_wr ? M_AT : M_BASE;
        M_BASE:  if (ops_wr) mode <= M_AT;
        M_SPEC:  if (ctl_rd && arm_at) mode <= M_AT;
        default: if (ctl_rd && arm_spec) mode <= M_SPEC;
      endcase
    end
  end

  logic [3:0] ds_dec_n;
  assign ds_dec_n = ~(4'b0001 << unit_sel);
  assign irq_oe   = (mode != M_HOLD);
  assign dma_oe   = (mode != M_HOLD);

  always_comb begin
    case (mode)
      M_HOLD: begin
        soft_rst  = 1'b1;
        dma_req_q = 1'b0;
        ds_n      = 4'b1111;
        rwc_n     = 1'b1;
      end
      M_BASE: begin
        soft_rst  = 1'b0;
        dma_req_q = dma_req_in;
        ds_n      = ds_dec_n;
        rwc_n     = ~wcur_req;
      end
      M_SPEC: begin
        soft_rst  = ~ops_q[2];
        dma_req_q = dma_req_in & ops_q[3];
        ds_n      = ds_dec_n;
        rwc_n     = ~wcur_req;
      end
      default: begin
        soft_rst  = ~ops_q[2];
        dma_req_q = dma_req_in & ops_q[3];
        ds_n      = ~{ops_q[5], ops_q[4], ops_q[1], ops_q[0]};
        rwc_n     = ~slow_rate;
      end
    endcase
  end
endmodule

// File: rtl/fdc_mode_seq_chk.sv
module fdc_mode_seq_chk (
  input logic       clk,
  input logic       rst_hw,
  input logic       acc_stb,
  input logic       acc_wr,
  input logic [1:0] acc_reg,
  input logic [1:0] unit_sel,
  input logic       dma_req_in,
  input logic [1:0] mode,
  input logic       soft_rst,
  input logic       irq_oe,
  input logic       dma_oe,
  input logic       dma_req_q,
  input logic [3:0] ds_n
);
  logic opw, ctr;
  assign opw = acc_stb & acc_wr & (acc_reg == 2'b01);
  assign ctr = acc_stb & ~acc_wr & (acc_reg == 2'b10);

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd0) |-> (soft_rst && !irq_oe && !dma_oe && !dma_req_q && ds_n == 4'b1111));

  // R2
  hold_to_base_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd0 && acc_stb && !opw) |=> (mode == 2'd1));

  // R2
  no_return_hold_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode != 2'd0) |=> (mode != 2'd0));

  // R3
  base_ignores_ops_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd1) |-> (!soft_rst && dma_req_q == dma_req_in && irq_oe && dma_oe));

  // R4
  ops_write_to_at_chk: assert property (@(posedge clk) disable iff (rst_hw)
    ((mode == 2'd0 || mode == 2'd1) && opw) |=> (mode == 2'd3));

  // R5
  at_needs_ctl_read_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd3 && !ctr) |=> (mode == 2'd3));

  // R6
  spec_needs_ctl_read_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd2 && !ctr) |=> (mode == 2'd2));

  // R8
  ds_decode_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (mode == 2'd1 || mode == 2'd2) |-> ($countones(~ds_n) == 1 && !ds_n[unit_sel]));
endmodule

bind fdc_mode_seq fdc_mode_seq_chk u_chk (
  .clk(clk), .rst_hw(rst_hw), .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_reg(acc_reg),
  .unit_sel(unit_sel), .dma_req_in(dma_req_in), .mode(mode), .soft_rst(soft_rst),
  .irq_oe(irq_oe), .dma_oe(dma_oe), .dma_req_q(dma_req_q), .ds_n(ds_n)
);

// File: tb/test_fdc_mode_seq.sv
module test_fdc_mode_seq;
  logic       clk = 1'b0;
  logic       rst_hw = 1'b1;
  logic       acc_stb = 1'b0, acc_wr = 1'b0;
  logic [1:0] acc_reg = 2'b00;
  logic [7:0] ops_wdata = 8'h00;
  logic [1:0] unit_sel = 2'd0;
  logic       dma_req_in = 1'b0, wcur_req = 1'b0, slow_rate = 1'b0;
  logic [1:0] mode;
  logic       soft_rst, irq_oe, dma_oe, dma_req_q, rwc_n;
  logic [3:0] ds_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdc_mode_seq i_fdc_mode_seq (
    .clk(clk), .rst_hw(rst_hw), .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_reg(acc_reg),
    .ops_wdata(ops_wdata), .unit_sel(unit_sel), .dma_req_in(dma_req_in),
    .wcur_req(wcur_req), .slow_rate(slow_rate), .mode(mode), .soft_rst(soft_rst),
    .irq_oe(irq_oe), .dma_oe(dma_oe), .dma_req_q(dma_req_q), .ds_n(ds_n), .rwc_n(rwc_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] r, input logic [7:0] d);
    @(negedge clk);
    acc_stb = 1'b1; acc_wr = w; acc_reg = r; ops_wdata = d;
    @(negedge clk);
    acc_stb = 1'b0; acc_wr = 1'b0; acc_reg = 2'b00;
    #1;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_hw = 1'b1;
    repeat (2) @(negedge clk);
    rst_hw = 1'b0; #1;
  endtask

  task automatic t_reset_state();
    dma_req_in = 1'b1; wcur_req = 1'b1; hard_reset();
    chk("R1 mode", {6'd0, mode}, 8'd0);
    chk("R1 soft_rst", {7'd0, soft_rst}, 8'd1);
    chk("R1 oe", {6'd0, irq_oe, dma_oe}, 8'd0);
    chk("R1 dma_req_q", {7'd0, dma_req_q}, 8'd0);
    chk("R1 ds_n", {4'd0, ds_n}, 8'h0F);
    chk("R1 rwc_n", {7'd0, rwc_n}, 8'd1);
  endtask

  task automatic t_base_entry();
    access(1'b0, 2'b00, 8'h00);
    chk("R2 R12 mode base", {6'd0, mode}, 8'd1);
    chk("R2 soft_rst", {7'd0, soft_rst}, 8'd0);
    chk("R2 oe", {6'd0, irq_oe, dma_oe}, 8'd3);
  endtask

  task automatic t_base_behaviour();
    dma_req_in = 1'b1; #1;
    chk("R3 dma pass", {7'd0, dma_req_q}, 8'd1);
    chk("R3 no soft_rst", {7'd0, soft_rst}, 8'd0);
    for (int k = 0; k < 4; k++) begin
      unit_sel = 2'(k); #1;
      chk("R8 base decode", {4'd0, ds_n}, {4'd0, ~(4'b0001 << k)});
    end
    wcur_req = 1'b1; slow_rate = 1'b0; #1;
    chk("R11 base rwc", {7'd0, rwc_n}, 8'd0);
    wcur_req = 1'b0; slow_rate = 1'b1; #1;
    chk("R11 base rwc slow ignored", {7'd0, rwc_n}, 8'd1);
    access(1'b0, 2'b10, 8'h00);
    chk("R7 ctl read in base", {6'd0, mode}, 8'd1);
  endtask

  task automatic t_at_from_base();
    access(1'b1, 2'b01, 8'h0C);
    chk("R4 base to at", {6'd0, mode}, 8'd3);
    chk("R10 at soft_rst off", {7'd0, soft_rst}, 8'd0);
    dma_req_in = 1'b1; #1;
    chk("R10 dma enabled", {7'd0, dma_req_q}, 8'd1);
    chk("R9 ds_n 0C", {4'd0, ds_n}, 8'h0F);
    access(1'b1, 2'b01, 8'h31);
    chk("R9 ds_n 31", {4'd0, ds_n}, 8'h02);
    chk("R10 dma gated", {7'd0, dma_req_q}, 8'd0);
    chk("R10 soft_rst on", {7'd0, soft_rst}, 8'd1);
    wcur_req = 1'b0; slow_rate = 1'b1; #1;
    chk("R11 at rpm", {7'd0, rwc_n}, 8'd0);
    wcur_req = 1'b1; slow_rate = 1'b0; #1;
    chk("R11 at wcur ignored", {7'd0, rwc_n}, 8'd1);
  endtask

  task automatic t_arm_clear();
    access(1'b1, 2'b01, 8'h80);
    access(1'b1, 2'b01, 8'h84);
    access(1'b0, 2'b10, 8'h00);
    chk("R7 arm cleared", {6'd0, mode}, 8'd3);
    access(1'b1, 2'b01, 8'hC0);
    access(1'b0, 2'b00, 8'h00);
    chk("R5 status read keeps at", {6'd0, mode}, 8'd3);
  endtask

  task automatic t_special_entry();
    access(1'b1, 2'b01, 8'h88);
    chk("R5 armed not yet", {6'd0, mode}, 8'd3);
    access(1'b0, 2'b10, 8'h00);
    chk("R5 R12 to special", {6'd0, mode}, 8'd2);
    chk("R10 special soft_rst", {7'd0, soft_rst}, 8'd1);
    access(1'b1, 2'b01, 8'h8C);
    chk("R10 special release", {7'd0, soft_rst}, 8'd0);
    dma_req_in = 1'b1; #1;
    chk("R10 special dma", {7'd0, dma_req_q}, 8'd1);
    unit_sel = 2'd2; #1;
    chk("R8 special decode", {4'd0, ds_n}, 8'h0B);
    wcur_req = 1'b1; slow_rate = 1'b0; #1;
    chk("R11 special rwc", {7'd0, rwc_n}, 8'd0);
    access(1'b1, 2'b01, 8'h00);
    access(1'b0, 2'b10, 8'h00);
    chk("R6 special to at", {6'd0, mode}, 8'd3);
    access(1'b0, 2'b10, 8'h00);
    chk("R7 arm consumed", {6'd0, mode}, 8'd3);
  endtask

  task automatic t_at_from_hold();
    hard_reset();
    chk("R1 back in hold", {6'd0, mode}, 8'd0);
    access(1'b1, 2'b01, 8'h24);
    chk("R4 hold to at", {6'd0, mode}, 8'd3);
    chk("R9 ds_n 24", {4'd0, ds_n}, 8'h07);
    chk("R10 soft_rst off", {7'd0, soft_rst}, 8'd0);
    hard_reset();
    access(1'b0, 2'b10, 8'h00);
    chk("R2 ctl read to base", {6'd0, mode}, 8'd1);
  endtask

  initial begin
    t_reset_state();
    t_base_entry();
    t_base_behaviour();
    t_at_from_base();
    t_arm_clear();
    t_special_entry();
    t_at_from_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule